// File: doc/BRIEF.md
# Memory Wait-State Generator

This block stretches bus cycles for a set of memory and bus device classes. Each class has its own programmed number of wait clocks, held in a small register file reached through an 8-bit write/read port. When a cycle-start strobe is seen while the block is idle, the wait value for the presented class code is loaded into a down counter. `busy` stays high for that many clocks, and `ready` then pulses for one clock.

The ROM-type class is programmed in two halves, and its wait is their sum. A phase marker output is low while the first half runs and high while the second half runs.

The block also divides the clock into a periodic refresh request tick: 512 ticks per 8 ms, or half that rate when a control bit is set. DRAM signalling, address multiplexing and the refresh itself happen elsewhere.

Top module: `waitgen_top`

## Requirements
- R1: After reset, the registers read as follows: address 0 reads 0x3F, address 1 reads 0x03, and addresses 2, 3 and 4 read 0x0F.
- R2: Only these register bits are implemented:
  - address 0: bits [2:0] hold the ROM first-half wait and bits [5:3] hold the ROM second-half wait;
  - address 1: bits [1:0] hold the shared DRAM row wait and bit 2 is the slow refresh bit;
  - addresses 2, 3 and 4: bits [3:0] hold the chip select 0, chip select 1 and ISA waits.

  All other bits, and all of addresses 5 to 7, read as zero and ignore writes.
- R3: A start accepted on a clock edge with wait value N gives N clocks of `busy` after that edge, then one clock of `ready`. When N is 0, `ready` is high in the clock right after the start edge and `busy` never rises.
- R4: The class code picks the wait value:
  - 0 picks the ROM first half plus the ROM second half;
  - 1 to 4 all pick the shared DRAM value;
  - 5 picks chip select 0;
  - 6 picks chip select 1;
  - 7 picks ISA.
- R5: During a ROM-type cycle, `half2` is low for the first-half number of busy clocks and high for the remaining second-half clocks. For every other class, `half2` stays low.
- R6: A start strobe while `busy` is high is ignored: the cycle is not lengthened and no extra `ready` appears.
- R7: `refresh_tick` is a one-clock pulse every CLK_HZ/64000 clocks when the slow bit is 0, and every twice that many clocks when it is 1.
- R8: A register write while a cycle is in progress does not change the length of that cycle. The new value applies from the next start.
- R9: `ready` and `busy` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | Bus cycle start strobe |
| dev_class | input | 3 | Device class code for the starting cycle |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| ready | output | 1 | One-clock end-of-cycle pulse |
| busy | output | 1 | Wait states in progress |
| half2 | output | 1 | ROM-type second-half marker |
| refresh_tick | output | 1 | Periodic refresh request pulse |

## Verification
Random register contents combined with random class codes check that every class reaches its own field (R4). Varied half values separate a correct ROM sum and phase split from a design that counts only one half. Zero-wait and maximum-wait directed cycles probe the counter ends. Start pulses injected mid-count and register writes mid-count tell apart a design that restarts or re-reads its count from one that holds the latched count. Tick intervals are measured at both refresh rates.

// File: rtl/waitgen_pkg.sv
package waitgen_pkg;
  parameter int DATA_W  = 8;
  parameter int ADDR_W  = 3;
  parameter int CLASS_W = 3;
  parameter int ROM_W   = 3;
  parameter int DRAM_W  = 2;
  parameter int CS_W    = 4;
  parameter int ISA_W   = 4;
  parameter int REFRESH_PER_SEC = 64000;

  localparam int ROM_MAX  = (1 << ROM_W) - 1;
  localparam int DRAM_MAX = (1 << DRAM_W) - 1;
  localparam int CS_MAX   = (1 << CS_W) - 1;
  localparam int ISA_MAX  = (1 << ISA_W) - 1;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int TOTAL_MAX = imax(imax(2 * ROM_MAX, DRAM_MAX), imax(CS_MAX, ISA_MAX));
  localparam int CNT_W     = $clog2(TOTAL_MAX + 1);

  localparam logic [ADDR_W-1:0] REG_ROM  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] REG_DRAM = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] REG_CS0  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] REG_CS1  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] REG_ISA  = ADDR_W'(4);

  localparam logic [CLASS_W-1:0] CLS_ROM = CLASS_W'(0);
  localparam logic [CLASS_W-1:0] CLS_CS0 = CLASS_W'(5);
  localparam logic [CLASS_W-1:0] CLS_CS1 = CLASS_W'(6);
  localparam logic [CLASS_W-1:0] CLS_ISA = CLASS_W'(7);

  typedef struct packed {
    logic [ROM_W-1:0]  rom_a;
    logic [ROM_W-1:0]  rom_b;
    logic [DRAM_W-1:0] dram;
    logic [CS_W-1:0]   cs0;
    logic [CS_W-1:0]   cs1;
    logic [ISA_W-1:0]  isa;
    logic              slow;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{
    rom_a: ROM_W'(ROM_MAX),
    rom_b: ROM_W'(ROM_MAX),
    dram:  DRAM_W'(DRAM_MAX),
    cs0:   CS_W'(CS_MAX),
    cs1:   CS_W'(CS_MAX),
    isa:   ISA_W'(ISA_MAX),
    slow:  1'b0
  };
endpackage

// File: rtl/waitgen_regs.sv
module waitgen_regs
  import waitgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output cfg_t              cfg
);
  cfg_t cfg_q, cfg_n;
  logic unused_wdata;

  assign unused_wdata = ^wdata[DATA_W-1:2*ROM_W];

  // next-state: write decode
  always_comb begin
    cfg_n = cfg_q;
    if (wr_en) begin
      unique case (addr)
        REG_ROM: begin
          cfg_n.rom_a = wdata[ROM_W-1:0];
          cfg_n.rom_b = wdata[2*ROM_W-1:ROM_W];
        end
        REG_DRAM: begin
          cfg_n.dram = wdata[DRAM_W-1:0];
          cfg_n.slow = wdata[DRAM_W];
        end
        REG_CS0: cfg_n.cs0 = wdata[CS_W-1:0];
        REG_CS1: cfg_n.cs1 = wdata[CS_W-1:0];
        REG_ISA: cfg_n.isa = wdata[ISA_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else if (wr_en) cfg_q <= cfg_n;
  end

  // read mux: unimplemented bits stay zero
  always_comb begin
    rdata = '0;
    unique case (addr)
      REG_ROM:  rdata[2*ROM_W-1:0] = {cfg_q.rom_b, cfg_q.rom_a};
      REG_DRAM: rdata[DRAM_W:0]    = {cfg_q.slow, cfg_q.dram};
      REG_CS0:  rdata[CS_W-1:0]    = cfg_q.cs0;
      REG_CS1:  rdata[CS_W-1:0]    = cfg_q.cs1;
      REG_ISA:  rdata[ISA_W-1:0]   = cfg_q.isa;
      default:  rdata = '0;
    endcase
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/waitgen_seq.sv
module waitgen_seq
  import waitgen_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_start,
  input  logic [CLASS_W-1:0] dev_class,
  input  cfg_t               cfg,
  output logic               ready,
  output logic               busy,
  output logic               half2
);
  logic [CNT_W-1:0] load_cnt, load_sec;
  logic [CNT_W-1:0] cnt_q, cnt_n, sec_q, sec_n;
  logic             busy_q, busy_n, rdy_q, rdy_n;
  logic             unused_slow;

  assign unused_slow = cfg.slow;

  // class decode: total wait and second-half share
  always_comb begin
    load_sec = '0;
    unique case (dev_class)
      CLS_ROM: begin
        load_cnt = CNT_W'(cfg.rom_a) + CNT_W'(cfg.rom_b);
        load_sec = CNT_W'(cfg.rom_b);
      end
      CLS_CS0: load_cnt = CNT_W'(cfg.cs0);
      CLS_CS1: load_cnt = CNT_W'(cfg.cs1);
      CLS_ISA: load_cnt = CNT_W'(cfg.isa);
      default: load_cnt = CNT_W'(cfg.dram);
    endcase
  end

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    sec_n  = sec_q;
    rdy_n  = 1'b0;
    if (busy_q) begin
      if (cnt_q == CNT_W'(1)) begin
        busy_n = 1'b0;
        rdy_n  = 1'b1;
        cnt_n  = '0;
      end else begin
        cnt_n = cnt_q - CNT_W'(1);
      end
    end else if (cyc_start) begin
      if (load_cnt == '0) begin
        rdy_n = 1'b1;
      end else begin
        busy_n = 1'b1;
        cnt_n  = load_cnt;
        sec_n  = load_sec;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sec_q  <= '0;
      rdy_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      sec_q  <= sec_n;
      rdy_q  <= rdy_n;
    end
  end

  assign ready = rdy_q;
  assign busy  = busy_q;
  assign half2 = busy_q && (cnt_q <= sec_q);
endmodule

// File: rtl/waitgen_refresh.sv
module waitgen_refresh
  import waitgen_pkg::*;
#(
  parameter int CLK_HZ = 250_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow,
  output logic tick
);
  localparam int FAST_DIV = CLK_HZ / REFRESH_PER_SEC;
  localparam int SLOW_DIV = 2 * FAST_DIV;
  localparam int DIV_W    = $clog2(SLOW_DIV + 1);
  localparam logic [DIV_W-1:0] FAST_END = DIV_W'(FAST_DIV - 1);
  localparam logic [DIV_W-1:0] SLOW_END = DIV_W'(SLOW_DIV - 1);

  logic [DIV_W-1:0] cnt_q, cnt_n, end_val;
  logic             tick_q, tick_n;

  assign end_val = slow ? SLOW_END : FAST_END;

  always_comb begin
    tick_n = 1'b0;
    cnt_n  = cnt_q + DIV_W'(1);
    if (cnt_q >= end_val) begin
      cnt_n  = '0;
      tick_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      tick_q <= tick_n;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/waitgen_top.sv
module waitgen_top
  import waitgen_pkg::*;
#(
  parameter int CLK_HZ = 250_000_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_start,
  input  logic [CLASS_W-1:0] dev_class,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               ready,
  output logic               busy,
  output logic               half2,
  output logic               refresh_tick
);
  cfg_t cfg;

  waitgen_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cfg   (cfg)
  );

  waitgen_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_start (cyc_start),
    .dev_class (dev_class),
    .cfg       (cfg),
    .ready     (ready),
    .busy      (busy),
    .half2     (half2)
  );

  waitgen_refresh #(.CLK_HZ(CLK_HZ)) u_refresh (
    .clk   (clk),
    .rst_n (rst_n),
    .slow  (cfg.slow),
    .tick  (refresh_tick)
  );
endmodule

// File: rtl/waitgen_chk.sv
module waitgen_chk
  import waitgen_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_start,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              ready,
  input logic              busy,
  input logic              half2,
  input logic              refresh_tick
);
  assert_ready_excl_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && busy));

  assert_busy_end_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ready);

  assert_ready_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ($past(busy) || $past(cyc_start)));

  assert_busy_needs_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cyc_start));

  assert_half2_inside_R5: assert property (@(posedge clk) disable iff (!rst_n)
    half2 |-> busy);

  assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_tick |=> !refresh_tick);

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > ADDR_W'(4)) |-> (reg_rdata == '0));
endmodule

bind waitgen_top waitgen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cyc_start    (cyc_start),
  .reg_addr     (reg_addr),
  .reg_rdata    (reg_rdata),
  .ready        (ready),
  .busy         (busy),
  .half2        (half2),
  .refresh_tick (refresh_tick)
);

// File: tb/waitgen_top_bench.sv
`timescale 1ns/1ps
module waitgen_top_bench;
  logic       clk, rst_n, cyc_start, reg_wr;
  logic [2:0] dev_class, reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       ready, busy, half2, refresh_tick;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] sh [0:4];

  waitgen_top u_waitgen_top (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .dev_class(dev_class),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ready(ready), .busy(busy), .half2(half2),
    .refresh_tick(refresh_tick)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mask_of(input int a);
    case (a)
      0: return 8'h3F;
      1: return 8'h07;
      2, 3, 4: return 8'h0F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int exp_wait(input int c);
    case (c)
      0: return int'(sh[0][2:0]) + int'(sh[0][5:3]);
      1, 2, 3, 4: return int'(sh[1][1:0]);
      5: return int'(sh[2][3:0]);
      6: return int'(sh[3][3:0]);
      default: return int'(sh[4][3:0]);
    endcase
  endfunction

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a < 5) sh[a] = d & mask_of(a);
  endtask

  task automatic rd_check(input int a, input string req);
    @(negedge clk);
    reg_addr = 3'(a);
    #1;
    check(req, int'(reg_rdata), (a < 5) ? int'(sh[a]) : 0);
  endtask

  // runs one cycle; inject: start pulses during busy clocks 1..3;
  // wr_mid: write chip select 1 = 1 during the first busy clock
  task automatic run_cycle(input int c, input bit inject, input bit wr_mid, input string req);
    int expn, first, n, rdy_seen;
    expn = exp_wait(c);
    first = int'(sh[0][2:0]);
    @(negedge clk);
    cyc_start = 1'b1; dev_class = 3'(c);
    @(negedge clk);
    cyc_start = 1'b0;
    n = 0;
    rdy_seen = 0;
    while (busy && n < 40) begin
      check({req, " R5 half2"}, int'(half2), (c == 0 && n >= first) ? 1 : 0);
      check({req, " R9 ready low while busy"}, int'(ready), 0);
      if (wr_mid && n == 0) begin reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 8'h01; end
      else reg_wr = 1'b0;
      cyc_start = inject && n >= 1 && n <= 3;
      n++;
      @(negedge clk);
    end
    reg_wr = 1'b0;
    cyc_start = 1'b0;
    if (wr_mid) sh[3] = 8'h01;
    check({req, " R3 busy length"}, n, expn);
    check({req, " R3 ready pulse"}, int'(ready), 1);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      if (ready) rdy_seen++;
    end
    check({req, " R6 no extra ready"}, rdy_seen, 0);
  endtask

  task automatic measure_tick(input int exp, input string req);
    int gap;
    gap = 0;
    while (!refresh_tick && gap < 20000) begin @(negedge clk); gap++; end
    @(negedge clk);
    gap = 1;
    while (!refresh_tick && gap < 20000) begin @(negedge clk); gap++; end
    check(req, gap, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; cyc_start = 1'b0; reg_wr = 1'b0;
    dev_class = '0; reg_addr = '0; reg_wdata = '0;
    sh[0] = 8'h3F; sh[1] = 8'h03; sh[2] = 8'h0F; sh[3] = 8'h0F; sh[4] = 8'h0F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 idle after reset busy", int'(busy), 0);
    check("R3 idle after reset ready", int'(ready), 0);
    for (int a = 0; a < 8; a++) rd_check(a, "R1 reset value");

    // R2: all-ones writes then reads
    for (int a = 0; a < 8; a++) wr(a, 8'hFF);
    for (int a = 0; a < 8; a++) rd_check(a, "R2 masked write");

    // R3/R4 directed: reset-like maximum ROM, zero-wait classes
    run_cycle(0, 0, 0, "R4 rom max");
    wr(2, 8'h00);
    run_cycle(5, 0, 0, "R3 zero wait cs0");
    wr(0, 8'b00_101_000);
    run_cycle(0, 0, 0, "R5 rom first zero");
    wr(0, 8'b00_000_110);
    run_cycle(0, 0, 0, "R5 rom second zero");
    wr(0, 8'b00_011_010);
    run_cycle(0, 0, 0, "R5 rom split");

    // R6: starts injected during a count
    wr(2, 8'h08);
    run_cycle(5, 1, 0, "R6 start while busy");

    // R8: write during a cycle
    wr(3, 8'h06);
    run_cycle(6, 0, 1, "R8 mid write current");
    run_cycle(6, 0, 0, "R8 mid write next");

    // random mix for R4
    for (int i = 0; i < 60; i++) begin
      wr(int'($urandom_range(0, 7)), 8'($urandom));
      run_cycle(int'($urandom_range(0, 7)), 0, 0, "R4 random class");
    end
    for (int a = 0; a < 8; a++) rd_check(a, "R2 random readback");

    // R7: refresh intervals
    wr(1, 8'h00);
    measure_tick(250000000 / 64000, "R7 fast tick interval");
    wr(1, 8'h04);
    measure_tick(2 * (250000000 / 64000), "R7 slow tick interval");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule